// File: doc/BRIEF.md
# Test Coprocessor with Timed Interrupts

This block is a helper coprocessor for processor test programs. It owns sixteen 32-bit scratch registers that the core reaches with register-move reads and writes under either of its two coprocessor numbers, and with load/store data transfers under the first number only. Its data-processing commands do no arithmetic. They stall the core for a programmed number of cycles, raise a fast or a normal interrupt after a programmed delay, drop either interrupt again, or capture a free-running cycle count into a register.

The core presents one request per cycle. The request carries a valid flag, the coprocessor number (first or second), the transfer kind, a first-cycle flag that separates the opening cycle of a command from its busy polls, and a data-beat flag for load/store transfers. The block replies in the same cycle with one of four responses and, for reads, the data. Register writes, counter loads and interrupt changes take effect at the next rising clock edge. The two interrupt outputs are active low. Each has its own delay counter, so both can be pending at once.

Top module: `tcp_test_copro`

## Requirements
- R1: After reset, fiq_n and irq_n are 1, every register reads 0 and the cycle counter is 0.
- R2: Transfer kind 0 (move read) returns the register selected by instruction bits 19:16 on cp_rdata. Kind 1 (move write) stores cp_wdata into that register at the next edge. Both kinds answer done (code 0) under either coprocessor number.
- R3: Kind 2 (load) with cp_data_beat set writes cp_wdata into the register selected by bits 15:12. Kind 3 (store) with cp_data_beat set returns that register on cp_rdata. Under the second number, both kinds answer cant (code 2) and change nothing.
- R4: A load/store data beat with bit 22 set answers increment (code 3) until LONG_BEATS such beats have been counted, then answers done. A beat with bit 22 clear answers done. A non-data phase (cp_data_beat low) answers done and clears the beat count.
- R5: Command kind 4 with opcode 0 (bits 23:20) is a busy-wait. The delay D is taken from the register selected by bits 3:0. On its first cycle at count c it answers done if D is 0 and busy (code 1) otherwise. A poll (cp_first low) at count t answers done once t-c is at least D, and busy before that.
- R6: Under the first number, any command opcode other than 0 answers cant. Under the second number, opcodes above 5 answer cant. Transfer kinds 5 to 7 answer cant. A refused request changes no register and no interrupt.
- R7: Opcode 1 (fast) or 2 (normal) on a first cycle under the second number, with delay 0, drives the matching interrupt low after that edge.
- R8: With delay D>0, the interrupt goes low after the D-th edge that follows the command edge. A new schedule on the same line restarts its count.
- R9: The fast and normal delay counters run independently, so both interrupts can be pending and can fire at different times.
- R10: Opcodes 3 and 4 drive fast and normal interrupt high again. An interrupt stays low until its deassert opcode is issued. A deassert does not cancel a pending count. When a count expires in the same cycle as a deassert, the line ends low.
- R11: Opcode 5 on a first cycle writes into the register selected by bits 3:0 the cycle count of that cycle. The count is the number of edges since reset was released.
- R12: With cp_valid low, or for a command poll with an opcode from 1 to 5, the response is done and nothing changes. cp_rdata is 0 whenever the request is not a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cp_valid | input | 1 | Request present this cycle |
| cp_second | input | 1 | 0: first coprocessor number, 1: second |
| cp_xfer | input | 3 | 0 move read, 1 move write, 2 load, 3 store, 4 command |
| cp_first | input | 1 | First cycle of a command (low on busy polls) |
| cp_data_beat | input | 1 | Load/store data phase (low for a non-data phase) |
| cp_instr | input | 32 | Instruction word carrying the register and opcode fields |
| cp_wdata | input | 32 | Write data for move writes and loads |
| cp_resp | output | 2 | 0 done, 1 busy, 2 cant, 3 increment |
| cp_rdata | output | 32 | Read data for move reads and stores, else 0 |
| fiq_n | output | 1 | Fast interrupt, active low |
| irq_n | output | 1 | Normal interrupt, active low |

## Verification
Two functions can fall in the same cycle here: a delay count that reaches expiry, and a deassert opcode for the same line. The bench schedules a fast interrupt with a delay of three and issues the deassert command exactly three cycles later, so both act at the same edge. A behavioural model built from the requirements expects the line to end low in that case. The bench also covers a deassert issued while a count is still pending, and both counters running at once with different delays. Each cycle it compares the response, read data and both interrupt lines against the model.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

    typedef enum logic [1:0] {
        RSP_DONE = 2'd0,
        RSP_BUSY = 2'd1,
        RSP_CANT = 2'd2,
        RSP_INC  = 2'd3
    } rsp_e;

    typedef enum logic [2:0] {
        XF_MOVE_RD = 3'd0,
        XF_MOVE_WR = 3'd1,
        XF_LOAD    = 3'd2,
        XF_STORE   = 3'd3,
        XF_CMD     = 3'd4
    } xfer_e;

    localparam logic [3:0] CMD_WAIT     = 4'd0;
    localparam logic [3:0] CMD_FAST     = 4'd1;
    localparam logic [3:0] CMD_NORM     = 4'd2;
    localparam logic [3:0] CMD_FAST_OFF = 4'd3;
    localparam logic [3:0] CMD_NORM_OFF = 4'd4;
    localparam logic [3:0] CMD_STAMP    = 4'd5;

    localparam int CH_FAST = 0;
    localparam int CH_NORM = 1;
    localparam int NUM_CH  = 2;

endpackage

// File: rtl/tcp_regfile.sv
module tcp_regfile #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic [AW-1:0]     daddr,
    output logic [DATA_W-1:0] ddata
);

    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = regs_q[raddr];
    assign ddata = regs_q[daddr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_q[$past(waddr)] == $past(wdata)) else $error("write lost"); // R2

endmodule

// File: rtl/tcp_irq_chan.sv
module tcp_irq_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sched,
    input  logic             clr,
    input  logic [CNT_W-1:0] delay,
    output logic             irq_n
);

    typedef struct packed {
        logic             level;
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } chan_t;

    chan_t st_d, st_q;
    logic  expire;

    assign expire = st_q.pend && (st_q.cnt == CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (st_q.pend && !expire) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (clr) begin
            st_d.level = 1'b0;
        end
        if (expire) begin
            st_d.level = 1'b1;
            st_d.pend  = 1'b0;
        end
        if (sched) begin
            if (delay == '0) begin
                st_d.level = 1'b1;
                st_d.pend  = 1'b0;
            end else begin
                st_d.pend = 1'b1;
                st_d.cnt  = delay;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = ~st_q.level;

    AST_ZERO_DELAY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (sched && delay == '0) |=> !irq_n) else $error("zero delay"); // R7
    AST_LOW_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !clr) |=> !irq_n) else $error("dropped"); // R10
    AST_RISE_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(clr)) else $error("rise"); // R10

endmodule

// File: rtl/tcp_decode.sv
module tcp_decode
    import tcp_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int AW         = 4,
    parameter int BEAT_W     = 3,
    parameter int LONG_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              is_second,
    input  logic [2:0]        xfer,
    input  logic              first,
    input  logic              data_beat,
    input  logic [3:0]        opc,
    input  logic              long_xfer,
    input  logic [AW-1:0]     sel_move,
    input  logic [AW-1:0]     sel_ldst,
    input  logic [AW-1:0]     sel_op,
    input  logic [DATA_W-1:0] delay_val,
    input  logic [DATA_W-1:0] now,
    input  logic [DATA_W-1:0] finish_q,
    input  logic [BEAT_W-1:0] beat_q,
    output logic [1:0]        resp,
    output logic              rd_en,
    output logic [AW-1:0]     raddr,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic              wr_stamp,
    output logic [NUM_CH-1:0] sched,
    output logic [NUM_CH-1:0] clr,
    output logic              finish_load,
    output logic              beat_clr,
    output logic              beat_inc
);

    logic [DATA_W-1:0] elapsed_gap;
    logic              wait_over;
    logic              beats_full;

    assign elapsed_gap = now - finish_q;
    assign wait_over   = !elapsed_gap[DATA_W-1];
    assign beats_full  = (beat_q == BEAT_W'(LONG_BEATS));

    always_comb begin
        resp        = RSP_DONE;
        rd_en       = 1'b0;
        raddr       = sel_move;
        we          = 1'b0;
        waddr       = sel_move;
        wr_stamp    = 1'b0;
        sched       = '0;
        clr         = '0;
        finish_load = 1'b0;
        beat_clr    = 1'b0;
        beat_inc    = 1'b0;
        if (req_valid) begin
            case (xfer)
                XF_MOVE_RD: begin
                    rd_en = 1'b1;
                end
                XF_MOVE_WR: begin
                    we = 1'b1;
                end
                XF_LOAD, XF_STORE: begin
                    if (is_second) begin
                        resp = RSP_CANT;
                    end else if (!data_beat) begin
                        beat_clr = 1'b1;
                    end else begin
                        if (xfer == XF_LOAD) begin
                            we    = 1'b1;
                            waddr = sel_ldst;
                        end else begin
                            rd_en = 1'b1;
                            raddr = sel_ldst;
                        end
                        if (long_xfer && !beats_full) begin
                            resp     = RSP_INC;
                            beat_inc = 1'b1;
                        end
                    end
                end
                XF_CMD: begin
                    if (!is_second && opc != CMD_WAIT) begin
                        resp = RSP_CANT;
                    end else begin
                        case (opc)
                            CMD_WAIT: begin
                                if (first) begin
                                    finish_load = 1'b1;
                                    resp = (delay_val == '0) ? RSP_DONE : RSP_BUSY;
                                end else begin
                                    resp = wait_over ? RSP_DONE : RSP_BUSY;
                                end
                            end
                            CMD_FAST:     sched[CH_FAST] = first;
                            CMD_NORM:     sched[CH_NORM] = first;
                            CMD_FAST_OFF: clr[CH_FAST]   = first;
                            CMD_NORM_OFF: clr[CH_NORM]   = first;
                            CMD_STAMP: begin
                                we       = first;
                                waddr    = sel_op;
                                wr_stamp = first;
                            end
                            default: resp = RSP_CANT;
                        endcase
                    end
                end
                default: resp = RSP_CANT;
            endcase
        end
    end

    AST_BUSY_ONLY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        resp == RSP_BUSY |-> (xfer == XF_CMD && opc == CMD_WAIT)) else $error("busy"); // R5
    AST_INC_ONLY_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        resp == RSP_INC |-> (long_xfer && data_beat && !is_second)) else $error("inc"); // R4
    AST_REFUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        resp == RSP_CANT |-> (!we && sched == '0 && clr == '0 && !beat_inc)) else $error("cant"); // R6

endmodule

// File: rtl/tcp_test_copro.sv
module tcp_test_copro
    import tcp_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_REGS   = 16,
    parameter int LONG_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cp_valid,
    input  logic              cp_second,
    input  logic [2:0]        cp_xfer,
    input  logic              cp_first,
    input  logic              cp_data_beat,
    input  logic [31:0]       cp_instr,
    input  logic [DATA_W-1:0] cp_wdata,
    output logic [1:0]        cp_resp,
    output logic [DATA_W-1:0] cp_rdata,
    output logic              fiq_n,
    output logic              irq_n
);

    localparam int AW     = $clog2(NUM_REGS);
    localparam int BEAT_W = $clog2(LONG_BEATS + 1) + 1;

    typedef struct packed {
        logic [DATA_W-1:0] cyc;
        logic [DATA_W-1:0] finish;
        logic [BEAT_W-1:0] beat;
    } top_t;

    top_t st_d, st_q;

    logic [AW-1:0]     sel_move, sel_ldst, sel_op;
    logic [3:0]        opc;
    logic              long_xfer;
    logic              unused_bits;
    logic              rd_en, we, wr_stamp, finish_load, beat_clr, beat_inc;
    logic [AW-1:0]     raddr, waddr;
    logic [NUM_CH-1:0] sched, clr, line_n;
    logic [DATA_W-1:0] rf_rdata, delay_val, rf_wdata;

    assign sel_move    = cp_instr[16 +: AW];
    assign sel_ldst    = cp_instr[12 +: AW];
    assign sel_op      = cp_instr[0 +: AW];
    assign opc         = cp_instr[23:20];
    assign long_xfer   = cp_instr[22];
    assign unused_bits = ^{cp_instr[31:24], cp_instr[11:4]};

    tcp_decode #(
        .DATA_W(DATA_W), .AW(AW), .BEAT_W(BEAT_W), .LONG_BEATS(LONG_BEATS)
    ) u_decode (
        .clk(clk), .rst_n(rst_n),
        .req_valid(cp_valid), .is_second(cp_second), .xfer(cp_xfer),
        .first(cp_first), .data_beat(cp_data_beat),
        .opc(opc), .long_xfer(long_xfer),
        .sel_move(sel_move), .sel_ldst(sel_ldst), .sel_op(sel_op),
        .delay_val(delay_val), .now(st_q.cyc), .finish_q(st_q.finish), .beat_q(st_q.beat),
        .resp(cp_resp), .rd_en(rd_en), .raddr(raddr), .we(we), .waddr(waddr),
        .wr_stamp(wr_stamp), .sched(sched), .clr(clr),
        .finish_load(finish_load), .beat_clr(beat_clr), .beat_inc(beat_inc)
    );

    assign rf_wdata = wr_stamp ? st_q.cyc : cp_wdata;

    tcp_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(we), .waddr(waddr), .wdata(rf_wdata),
        .raddr(raddr), .rdata(rf_rdata),
        .daddr(sel_op), .ddata(delay_val)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tcp_irq_chan #(.CNT_W(DATA_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .sched(sched[c]), .clr(clr[c]), .delay(delay_val),
            .irq_n(line_n[c])
        );
    end

    assign fiq_n    = line_n[CH_FAST];
    assign irq_n    = line_n[CH_NORM];
    assign cp_rdata = rd_en ? rf_rdata : '0;

    always_comb begin
        st_d     = st_q;
        st_d.cyc = st_q.cyc + DATA_W'(1);
        if (finish_load) begin
            st_d.finish = st_q.cyc + delay_val;
        end
        if (beat_clr) begin
            st_d.beat = '0;
        end else if (beat_inc) begin
            st_d.beat = st_q.beat + BEAT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.cyc == $past(st_q.cyc) + DATA_W'(1)) else $error("cycle count"); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_valid |-> (cp_resp == RSP_DONE && cp_rdata == '0)) else $error("idle"); // R12

endmodule

// File: tb/tb_tcp_test_copro.sv
module tb_tcp_test_copro;

    localparam int CLK_PERIOD = 10;
    localparam int LONG = 4;
    localparam logic [2:0] XMR = 3'd0, XMW = 3'd1, XLD = 3'd2, XST = 3'd3, XCMD = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_valid = 1'b0, cp_second = 1'b0, cp_first = 1'b0, cp_data_beat = 1'b0;
    logic [2:0]  cp_xfer = '0;
    logic [31:0] cp_instr = '0, cp_wdata = '0;
    logic [1:0]  cp_resp;
    logic [31:0] cp_rdata;
    logic        fiq_n, irq_n;

    int checks = 0;
    int errors = 0;

    int unsigned m_regs [16];
    int unsigned m_cyc, m_finish, m_beats;
    bit          m_lvl [2];
    bit          m_pend [2];
    int unsigned m_cnt [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    tcp_test_copro dut (
        .clk(clk), .rst_n(rst_n), .cp_valid(cp_valid), .cp_second(cp_second),
        .cp_xfer(cp_xfer), .cp_first(cp_first), .cp_data_beat(cp_data_beat),
        .cp_instr(cp_instr), .cp_wdata(cp_wdata), .cp_resp(cp_resp),
        .cp_rdata(cp_rdata), .fiq_n(fiq_n), .irq_n(irq_n)
    );

    function automatic logic [31:0] mk(input logic [3:0] opc, input logic [3:0] crn,
                                       input logic [3:0] crd, input logic [3:0] crm);
        return {8'h00, opc, crn, crd, 8'h00, crm};
    endfunction

    task automatic check(input string tag, input string what, input int unsigned act,
                         input int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic v, input logic sec, input logic [2:0] x,
                        input logic fst, input logic bt, input logic [31:0] ins,
                        input logic [31:0] wd);
        int unsigned er, ed, dly, gap;
        int unsigned opc;
        bit          sch [2];
        bit          clrv [2];
        bit          we;
        int unsigned wa, wv;
        bit          fin_ld, bclr, binc;
        sch = '{0, 0}; clrv = '{0, 0};
        we = 0; wa = 0; wv = 0; fin_ld = 0; bclr = 0; binc = 0;
        cp_valid = v; cp_second = sec; cp_xfer = x; cp_first = fst;
        cp_data_beat = bt; cp_instr = ins; cp_wdata = wd;
        #1;
        er = 0; ed = 0;
        dly = m_regs[ins[3:0]];
        opc = ins[23:20];
        if (v) begin
            if (x == XMR) ed = m_regs[ins[19:16]];
            else if (x == XMW) begin we = 1; wa = ins[19:16]; wv = wd; end
            else if (x == XLD || x == XST) begin
                if (sec) er = 2;
                else if (!bt) bclr = 1;
                else begin
                    if (x == XLD) begin we = 1; wa = ins[15:12]; wv = wd; end
                    else ed = m_regs[ins[15:12]];
                    if (ins[22] && m_beats != LONG) begin er = 3; binc = 1; end
                end
            end else if (x == XCMD) begin
                if (!sec && opc != 0) er = 2;
                else if (opc == 0) begin
                    if (fst) begin fin_ld = 1; er = (dly == 0) ? 0 : 1; end
                    else begin
                        gap = m_cyc - m_finish;
                        er = (gap[31] == 1'b0) ? 0 : 1;
                    end
                end
                else if (opc == 1) sch[0] = fst;
                else if (opc == 2) sch[1] = fst;
                else if (opc == 3) clrv[0] = fst;
                else if (opc == 4) clrv[1] = fst;
                else if (opc == 5) begin
                    if (fst) begin we = 1; wa = ins[3:0]; wv = m_cyc; end
                end
                else er = 2;
            end else er = 2;
        end
        check(tag, "resp", cp_resp, er);
        check(tag, "rdata", cp_rdata, ed);
        check(tag, "fiq_n", fiq_n, !m_lvl[0]);
        check(tag, "irq_n", irq_n, !m_lvl[1]);
        @(posedge clk);
        for (int c = 0; c < 2; c++) begin
            bit ex;
            ex = m_pend[c] && m_cnt[c] == 1;
            if (m_pend[c] && !ex) m_cnt[c]--;
            if (clrv[c]) m_lvl[c] = 0;
            if (ex) begin m_lvl[c] = 1; m_pend[c] = 0; end
            if (sch[c]) begin
                if (dly == 0) begin m_lvl[c] = 1; m_pend[c] = 0; end
                else begin m_pend[c] = 1; m_cnt[c] = dly; end
            end
        end
        if (we) m_regs[wa] = wv;
        if (fin_ld) m_finish = m_cyc + dly;
        if (bclr) m_beats = 0;
        else if (binc) m_beats++;
        m_cyc++;
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, XMR, 0, 0, 32'h0, 32'h0);
    endtask

    task automatic wr(input string tag, input logic [3:0] r, input logic [31:0] val);
        step(tag, 1, 0, XMW, 1, 0, mk(4'd0, r, 4'd0, 4'd0), val);
    endtask

    task automatic cmd(input string tag, input logic [3:0] opc, input logic [3:0] crm);
        step(tag, 1, 1, XCMD, 1, 0, mk(opc, 4'd0, 4'd0, crm), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_regs[i] = 0;
        m_cyc = 0; m_finish = 0; m_beats = 0;
        m_lvl = '{0, 0}; m_pend = '{0, 0}; m_cnt = '{0, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        idle("R1", 2);
        step("R1", 1, 0, XMR, 1, 0, mk(4'd0, 4'd0, 4'd0, 4'd0), 32'h0);
        step("R1", 1, 1, XMR, 1, 0, mk(4'd0, 4'd15, 4'd0, 4'd0), 32'h0);
        cmd("R1", 4'd5, 4'd11);
        step("R1", 1, 0, XMR, 1, 0, mk(4'd0, 4'd11, 4'd0, 4'd0), 32'h0);

        // R2: moves under both numbers
        wr("R2", 4'd3, 32'hDEADBEEF);
        step("R2", 1, 1, XMR, 1, 0, mk(4'd0, 4'd3, 4'd0, 4'd0), 32'h0);
        step("R2", 1, 1, XMW, 1, 0, mk(4'd0, 4'd15, 4'd0, 4'd0), 32'h12345678);
        step("R2", 1, 0, XMR, 1, 0, mk(4'd0, 4'd15, 4'd0, 4'd0), 32'h0);

        // R3: load/store under first number, refused under second
        step("R3", 1, 0, XLD, 0, 0, mk(4'd0, 4'd0, 4'd7, 4'd0), 32'h0);
        step("R3", 1, 0, XLD, 0, 1, mk(4'd0, 4'd0, 4'd7, 4'd0), 32'hCAFE0007);
        step("R3", 1, 0, XST, 0, 1, mk(4'd0, 4'd0, 4'd7, 4'd0), 32'h0);
        step("R3", 1, 1, XLD, 0, 1, mk(4'd0, 4'd0, 4'd7, 4'd0), 32'h11111111);
        step("R3", 1, 1, XST, 0, 1, mk(4'd0, 4'd0, 4'd7, 4'd0), 32'h0);
        step("R3", 1, 0, XMR, 1, 0, mk(4'd0, 4'd7, 4'd0, 4'd0), 32'h0);

        // R4: long transfers
        step("R4", 1, 0, XLD, 0, 0, mk(4'd4, 4'd0, 4'd8, 4'd0), 32'h0);
        for (int i = 0; i < 6; i++)
            step("R4", 1, 0, XLD, 0, 1, mk(4'd4, 4'd0, 4'd8, 4'd0), 32'hA0 + i);
        step("R4", 1, 0, XST, 0, 0, mk(4'd4, 4'd0, 4'd8, 4'd0), 32'h0);
        for (int i = 0; i < 3; i++)
            step("R4", 1, 0, XST, 0, 1, mk(4'd4, 4'd0, 4'd8, 4'd0), 32'h0);
        step("R4", 1, 0, XST, 0, 1, mk(4'd0, 4'd0, 4'd8, 4'd0), 32'h0);

        // R5: busy-wait
        wr("R5", 4'd2, 32'd3);
        step("R5", 1, 0, XCMD, 1, 0, mk(4'd0, 4'd0, 4'd0, 4'd2), 32'h0);
        for (int i = 0; i < 4; i++)
            step("R5", 1, 0, XCMD, 0, 0, mk(4'd0, 4'd0, 4'd0, 4'd2), 32'h0);
        step("R5", 1, 1, XCMD, 1, 0, mk(4'd0, 4'd0, 4'd0, 4'd9), 32'h0);

        // R6: refused requests
        step("R6", 1, 0, XCMD, 1, 0, mk(4'd1, 4'd0, 4'd0, 4'd9), 32'h0);
        step("R6", 1, 1, XCMD, 1, 0, mk(4'd7, 4'd0, 4'd0, 4'd9), 32'h0);
        step("R6", 1, 0, 3'd5, 1, 0, mk(4'd0, 4'd3, 4'd0, 4'd0), 32'h55);
        step("R6", 1, 0, XMR, 1, 0, mk(4'd0, 4'd3, 4'd0, 4'd0), 32'h0);
        idle("R6", 1);

        // R7: zero-delay assertion, then R10 release
        cmd("R7", 4'd1, 4'd9);
        idle("R7", 2);
        cmd("R10", 4'd3, 4'd0);
        cmd("R7", 4'd2, 4'd9);
        cmd("R10", 4'd4, 4'd0);

        // R8: delayed assertion and reload
        cmd("R8", 4'd2, 4'd2);
        idle("R8", 5);
        cmd("R10", 4'd4, 4'd0);
        wr("R8", 4'd4, 32'd5);
        cmd("R8", 4'd1, 4'd4);
        idle("R8", 2);
        cmd("R8", 4'd1, 4'd2);
        idle("R8", 5);
        cmd("R10", 4'd3, 4'd0);

        // R9: both lines pending together
        cmd("R9", 4'd1, 4'd4);
        cmd("R9", 4'd2, 4'd2);
        idle("R9", 6);
        cmd("R10", 4'd3, 4'd0);
        cmd("R10", 4'd4, 4'd0);

        // R10: deassert in the expiry cycle, and deassert while pending
        cmd("R10", 4'd1, 4'd2);
        idle("R10", 2);
        cmd("R10", 4'd3, 4'd0);
        idle("R10", 1);
        cmd("R10", 4'd3, 4'd0);
        cmd("R10", 4'd2, 4'd4);
        cmd("R10", 4'd4, 4'd0);
        idle("R10", 5);
        cmd("R10", 4'd4, 4'd0);

        // R11: stamp capture
        cmd("R11", 4'd5, 4'd10);
        step("R11", 1, 0, XMR, 1, 0, mk(4'd0, 4'd10, 4'd0, 4'd0), 32'h0);
        idle("R11", 3);
        cmd("R11", 4'd5, 4'd10);
        step("R11", 1, 1, XMR, 1, 0, mk(4'd0, 4'd10, 4'd0, 4'd0), 32'h0);

        // R12: idle and command polls have no effect
        step("R12", 0, 1, XMW, 1, 1, mk(4'd0, 4'd3, 4'd3, 4'd3), 32'hFFFF);
        step("R12", 1, 1, XCMD, 0, 0, mk(4'd1, 4'd0, 4'd0, 4'd9), 32'h0);
        step("R12", 1, 1, XCMD, 0, 0, mk(4'd5, 4'd0, 4'd0, 4'd3), 32'h0);
        step("R12", 1, 0, XMR, 1, 0, mk(4'd0, 4'd3, 4'd0, 4'd0), 32'h0);
        idle("R12", 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule